// File: doc/BRIEF.md
# PCI Slot Hotplug Status Register Bank

This block tells firmware which PCI slots have gained or are about to lose a device. It keeps one bank per hotplug-capable bus, and each bank covers 32 slots. Two side-band event ports carry a bus number and a slot number. A plug event marks the slot in that bus's "arrived" bitmap. An unplug request marks the slot in that bus's "leaving" bitmap. Each accepted event raises a one-cycle notification pulse, and firmware services the notification through a word-wide register window.

Firmware first picks a bus through the bus-select register. It can then read the two pending bitmaps and the removable-slot mask. Writing a one-hot slot mask to the eject register retires a slot: the pending bits for that slot are dropped and an eject pulse carrying the bus and slot goes out. A second register looks up a naming index for a slot. A write to that register primes the lookup and the next read fetches the result.

The register port is a plain strobe interface with no back-pressure. A read strobe is always answered on `reg_rvalid` exactly one cycle later, and the requester must take the data in that cycle. Write strobes complete in the cycle they are presented.

Top module: `hp_status_bank`

## Requirements
- R1: After reset, every bitmap, the bus select and the naming-index holder read as zero, and `evt_pulse`, `eject_valid` and `reg_rvalid` are low.
- R2: A plug (unplug) event on a bus below NBUS whose `bus_ok_mask` bit is set sets bit `slot` of that bus's arrived (leaving) bitmap, and `evt_pulse` is high in the next cycle. An event on any other bus changes nothing and gives no pulse.
- R3: A read is answered one cycle after its strobe, with `reg_rvalid` high for one cycle. Offset 0x00 returns the arrived bitmap, 0x04 the leaving bitmap, 0x08 zero, 0x0C the removable mask (the inverse of the bus's `slot_fixed_mask` word), 0x10 the bus select and 0x14 the naming-index holder, zero-extended.
- R4: A write to 0x08 takes the slot as the position of the lowest set bit of the data. It clears that slot in both bitmaps of the selected bus. In the next cycle it pulses `eject_valid` with that bus and slot, unless the slot's `slot_fixed_mask` bit is set, in which case there is no pulse.
- R5: An eject write is ignored when the data is zero, or when the selected bus is not below NBUS or has its `bus_ok_mask` bit clear.
- R6: A read of 0x00 clears the arrived bitmap only when `cfg_bridge_mode` is 1. With `cfg_bridge_mode` at 0 the bitmap is left unchanged.
- R7: A write to 0x10 stores the full data word when `cfg_bridge_mode` is 1, and stores 0 otherwise. While the select is NBUS or above, every read returns zero.
- R8: Every accepted write clears the naming-index holder. A write to 0x14 on a valid selected bus with non-zero data then loads the index of the slot at the data's lowest set bit. A read of 0x14 returns the holder and clears it.
- R9: A plug and an unplug event in the same cycle are both applied. An event that sets a bit in the same cycle as an eject write or an arrived-bitmap read that clears it leaves the bit set.
- R10: An access is accepted only when `reg_be` is 4'hF and `reg_addr[1:0]` is 0. Any other strobe has no effect and gets no read response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bridge_mode | input | 1 | 1: bus select is writable and the arrived bitmap clears on read |
| bus_ok_mask | input | NBUS | Per-bus hotplug-capable flag |
| slot_fixed_mask | input | NBUS*32 | Per-slot non-removable flag, bus b at bits [b*32 +: 32] |
| slot_name_idx | input | NBUS*32*IDXW | Per-slot naming index, slot (b,s) at [(b*32+s)*IDXW +: IDXW] |
| plug_valid | input | 1 | Plug event strobe |
| plug_bus | input | EVB | Plug event bus number |
| plug_slot | input | 5 | Plug event slot number |
| unplug_valid | input | 1 | Unplug request strobe |
| unplug_bus | input | EVB | Unplug request bus number |
| unplug_slot | input | 5 | Unplug request slot number |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Byte offset |
| reg_be | input | 4 | Byte enables |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read response, one cycle after the strobe |
| evt_pulse | output | 1 | Notification pulse |
| eject_valid | output | 1 | Eject pulse |
| eject_bus | output | BW | Bus of the eject |
| eject_slot | output | 5 | Slot of the eject |

## Verification
The hardest cases to reach are the collisions in R9, where a bitmap bit is cleared and set in the same edge. They require an event strobe to line up with an eject write or a clearing read in the same cycle. The bench drives the event ports and the register strobe from one task at a single falling edge, then reads the bitmap back to see which side won. The naming-index holder is also easy to miss, because it loses its value on any other write. The bench primes it, writes the select register in between, and expects a zero read.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int WORD_W = 32;
  localparam int SLOTS  = 32;
  localparam int SLOT_W = 5;
  localparam int ADDR_W = 5;

  // Register offsets (bytes)
  localparam logic [ADDR_W-1:0] OFS_UP    = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_DOWN  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_EJECT = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_RMV   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_SEL   = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_NAME  = 5'h14;

  // Position of the lowest set bit; 32 (bit 5 set) when the word is zero.
  function automatic logic [SLOT_W:0] lowest_set(input logic [WORD_W-1:0] v);
    logic [SLOT_W:0] r;
    r = 6'd32;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (v[i]) r = 6'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/hp_bitmaps.sv
module hp_bitmaps
  import hp_pkg::*;
#(
  parameter int NBUS = 4,
  parameter int EVB  = 8,
  localparam int BW  = (NBUS > 1) ? $clog2(NBUS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NBUS-1:0]        bus_ok_mask,
  input  logic                   plug_valid,
  input  logic [EVB-1:0]         plug_bus,
  input  logic [SLOT_W-1:0]      plug_slot,
  input  logic                   unplug_valid,
  input  logic [EVB-1:0]         unplug_bus,
  input  logic [SLOT_W-1:0]      unplug_slot,
  input  logic                   ej_clr,
  input  logic [BW-1:0]          ej_bus,
  input  logic [SLOT_W-1:0]      ej_slot,
  input  logic                   up_rdclr,
  input  logic [BW-1:0]          rd_bus,
  output logic [NBUS*SLOTS-1:0]  up_flat,
  output logic [NBUS*SLOTS-1:0]  down_flat,
  output logic                   evt_pulse
);
  logic [NBUS-1:0] hit;

  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    logic [SLOTS-1:0] up_q, up_n, dn_q, dn_n;
    logic plug_hit, unplug_hit;

    assign plug_hit   = plug_valid   && (plug_bus   == EVB'(b)) && bus_ok_mask[b];
    assign unplug_hit = unplug_valid && (unplug_bus == EVB'(b)) && bus_ok_mask[b];
    assign hit[b]     = plug_hit || unplug_hit;

    // Clears first, sets last: a new event always survives.
    always_comb begin
      up_n = up_q;
      dn_n = dn_q;
      if (up_rdclr && rd_bus == BW'(b)) up_n = '0;
      if (ej_clr && ej_bus == BW'(b)) begin
        up_n[ej_slot] = 1'b0;
        dn_n[ej_slot] = 1'b0;
      end
      if (plug_hit)   up_n[plug_slot]   = 1'b1;
      if (unplug_hit) dn_n[unplug_slot] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        up_q <= '0;
        dn_q <= '0;
      end else begin
        up_q <= up_n;
        dn_q <= dn_n;
      end
    end

    assign up_flat[b*SLOTS +: SLOTS]   = up_q;
    assign down_flat[b*SLOTS +: SLOTS] = dn_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) evt_pulse <= 1'b0;
    else        evt_pulse <= |hit;
  end
endmodule

// File: rtl/hp_eject.sv
module hp_eject
  import hp_pkg::*;
#(
  parameter int NBUS = 4,
  localparam int BW  = (NBUS > 1) ? $clog2(NBUS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ej_req,
  input  logic [WORD_W-1:0]     ej_data,
  input  logic [BW-1:0]         sel_bus,
  input  logic [NBUS*SLOTS-1:0] fixed_flat,
  output logic                  ej_clr,
  output logic [SLOT_W-1:0]     ej_slot,
  output logic                  eject_valid,
  output logic [BW-1:0]         eject_bus,
  output logic [SLOT_W-1:0]     eject_slot
);
  logic [SLOT_W:0]      lsb;
  logic [BW+SLOT_W-1:0] fidx;
  logic                 is_fixed;

  assign lsb      = lowest_set(ej_data);
  assign ej_slot  = lsb[SLOT_W-1:0];
  assign ej_clr   = ej_req && !lsb[SLOT_W];
  assign fidx     = {sel_bus, ej_slot};
  assign is_fixed = fixed_flat[fidx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eject_valid <= 1'b0;
      eject_bus   <= '0;
      eject_slot  <= '0;
    end else begin
      eject_valid <= ej_clr && !is_fixed;
      if (ej_clr) begin
        eject_bus  <= sel_bus;
        eject_slot <= ej_slot;
      end
    end
  end
endmodule

// File: rtl/hp_regs.sv
module hp_regs
  import hp_pkg::*;
#(
  parameter int NBUS = 4,
  parameter int IDXW = 16,
  localparam int BW  = (NBUS > 1) ? $clog2(NBUS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_bridge_mode,
  input  logic [NBUS-1:0]            bus_ok_mask,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [3:0]                 reg_be,
  input  logic [WORD_W-1:0]          reg_wdata,
  input  logic [NBUS*SLOTS-1:0]      up_flat,
  input  logic [NBUS*SLOTS-1:0]      down_flat,
  input  logic [NBUS*SLOTS-1:0]      fixed_flat,
  input  logic [NBUS*SLOTS*IDXW-1:0] name_flat,
  output logic [WORD_W-1:0]          reg_rdata,
  output logic                       reg_rvalid,
  output logic [WORD_W-1:0]          sel_q,
  output logic [BW-1:0]              sel_bus,
  output logic                       ej_req,
  output logic                       up_rdclr
);
  logic                 acc_ok, wr_ok, rd_ok, sel_in, sel_hp;
  logic [IDXW-1:0]      name_q;
  logic [SLOT_W:0]      name_lsb;
  logic [BW+SLOT_W-1:0] nidx;
  logic [BW+SLOT_W-1:0] wbase;
  logic [WORD_W-1:0]    rd_mux;

  assign acc_ok  = (reg_be == 4'hF) && (reg_addr[1:0] == 2'b00);
  assign wr_ok   = reg_wr && acc_ok;
  assign rd_ok   = reg_rd && acc_ok;
  assign sel_in  = (sel_q < WORD_W'(NBUS));
  assign sel_bus = sel_q[BW-1:0];
  assign sel_hp  = sel_in && bus_ok_mask[sel_bus];

  assign ej_req   = wr_ok && (reg_addr == OFS_EJECT) && sel_hp;
  assign up_rdclr = rd_ok && (reg_addr == OFS_UP) && sel_in && cfg_bridge_mode;

  assign name_lsb = lowest_set(reg_wdata);
  assign nidx     = {sel_bus, name_lsb[SLOT_W-1:0]};
  assign wbase    = {sel_bus, {SLOT_W{1'b0}}};

  // Bus select
  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= '0;
    else if (wr_ok && reg_addr == OFS_SEL)
      sel_q <= cfg_bridge_mode ? reg_wdata : '0;
  end

  // Naming-index holder: read clears, any write clears, a name write loads
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      name_q <= '0;
    end else begin
      if (rd_ok && reg_addr == OFS_NAME) name_q <= '0;
      if (wr_ok) begin
        name_q <= '0;
        if (reg_addr == OFS_NAME && sel_hp && !name_lsb[SLOT_W])
          name_q <= name_flat[nidx*IDXW +: IDXW];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      OFS_UP:   rd_mux = up_flat[wbase +: SLOTS];
      OFS_DOWN: rd_mux = down_flat[wbase +: SLOTS];
      OFS_RMV:  rd_mux = ~fixed_flat[wbase +: SLOTS];
      OFS_SEL:  rd_mux = sel_q;
      OFS_NAME: rd_mux = WORD_W'(name_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= rd_ok;
      reg_rdata  <= (rd_ok && sel_in) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/hp_status_bank.sv
module hp_status_bank
  import hp_pkg::*;
#(
  parameter int NBUS = 4,
  parameter int EVB  = 8,
  parameter int IDXW = 16,
  localparam int BW  = (NBUS > 1) ? $clog2(NBUS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_bridge_mode,
  input  logic [NBUS-1:0]            bus_ok_mask,
  input  logic [NBUS*SLOTS-1:0]      slot_fixed_mask,
  input  logic [NBUS*SLOTS*IDXW-1:0] slot_name_idx,
  input  logic                       plug_valid,
  input  logic [EVB-1:0]             plug_bus,
  input  logic [SLOT_W-1:0]          plug_slot,
  input  logic                       unplug_valid,
  input  logic [EVB-1:0]             unplug_bus,
  input  logic [SLOT_W-1:0]          unplug_slot,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [3:0]                 reg_be,
  input  logic [WORD_W-1:0]          reg_wdata,
  output logic [WORD_W-1:0]          reg_rdata,
  output logic                       reg_rvalid,
  output logic                       evt_pulse,
  output logic                       eject_valid,
  output logic [BW-1:0]              eject_bus,
  output logic [SLOT_W-1:0]          eject_slot
);
  logic [NBUS*SLOTS-1:0] up_flat, down_flat;
  logic [WORD_W-1:0]     sel_q;
  logic [BW-1:0]         sel_bus;
  logic                  ej_req, up_rdclr, ej_clr;
  logic [SLOT_W-1:0]     ej_slot;

  hp_regs #(.NBUS(NBUS), .IDXW(IDXW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_bridge_mode(cfg_bridge_mode),
    .bus_ok_mask(bus_ok_mask), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
    .up_flat(up_flat), .down_flat(down_flat), .fixed_flat(slot_fixed_mask),
    .name_flat(slot_name_idx), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .sel_q(sel_q), .sel_bus(sel_bus), .ej_req(ej_req), .up_rdclr(up_rdclr)
  );

  hp_eject #(.NBUS(NBUS)) u_eject (
    .clk(clk), .rst_n(rst_n), .ej_req(ej_req), .ej_data(reg_wdata),
    .sel_bus(sel_bus), .fixed_flat(slot_fixed_mask), .ej_clr(ej_clr),
    .ej_slot(ej_slot), .eject_valid(eject_valid), .eject_bus(eject_bus),
    .eject_slot(eject_slot)
  );

  hp_bitmaps #(.NBUS(NBUS), .EVB(EVB)) u_maps (
    .clk(clk), .rst_n(rst_n), .bus_ok_mask(bus_ok_mask),
    .plug_valid(plug_valid), .plug_bus(plug_bus), .plug_slot(plug_slot),
    .unplug_valid(unplug_valid), .unplug_bus(unplug_bus), .unplug_slot(unplug_slot),
    .ej_clr(ej_clr), .ej_bus(sel_bus), .ej_slot(ej_slot),
    .up_rdclr(up_rdclr), .rd_bus(sel_bus),
    .up_flat(up_flat), .down_flat(down_flat), .evt_pulse(evt_pulse)
  );
endmodule

// File: rtl/hp_status_chk.sv
module hp_status_chk #(
  parameter int NBUS = 4,
  parameter int BW   = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_bridge_mode,
  input logic                 reg_wr,
  input logic                 reg_rd,
  input logic [4:0]           reg_addr,
  input logic [3:0]           reg_be,
  input logic [31:0]          reg_rdata,
  input logic                 reg_rvalid,
  input logic                 plug_valid,
  input logic                 unplug_valid,
  input logic                 evt_pulse,
  input logic                 eject_valid,
  input logic [BW-1:0]        eject_bus,
  input logic [4:0]           eject_slot,
  input logic [NBUS*32-1:0]   slot_fixed_mask,
  input logic [31:0]          sel_q
);
  assert_rvalid_after_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rvalid |-> $past(reg_rd && reg_be == 4'hF && reg_addr[1:0] == 2'b00));

  assert_evt_after_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |-> $past(plug_valid || unplug_valid));

  assert_eject_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eject_valid |-> $past(reg_wr && reg_addr == 5'h08));

  assert_eject_not_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eject_valid |-> !slot_fixed_mask[{eject_bus, eject_slot}]);

  assert_oor_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rvalid && $past(sel_q >= NBUS)) |-> reg_rdata == 32'h0);

  assert_sel_default_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cfg_bridge_mode && reg_wr && reg_addr == 5'h10 && reg_be == 4'hF) |-> sel_q == 32'h0);
endmodule

bind hp_status_bank hp_status_chk #(.NBUS(NBUS), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_bridge_mode(cfg_bridge_mode),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_be(reg_be),
  .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
  .plug_valid(plug_valid), .unplug_valid(unplug_valid), .evt_pulse(evt_pulse),
  .eject_valid(eject_valid), .eject_bus(eject_bus), .eject_slot(eject_slot),
  .slot_fixed_mask(slot_fixed_mask), .sel_q(sel_q)
);

// File: tb/sim_hp_status_bank.sv
`timescale 1ns/1ps
module sim_hp_status_bank;
  localparam int NBUS = 4;
  localparam int EVB  = 8;
  localparam int IDXW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_bridge_mode = 1'b1;
  logic [NBUS-1:0] bus_ok_mask = 4'b1011;
  logic [NBUS*32-1:0] slot_fixed_mask;
  logic [NBUS*32*IDXW-1:0] slot_name_idx;
  logic plug_valid = 0, unplug_valid = 0;
  logic [EVB-1:0] plug_bus = 0, unplug_bus = 0;
  logic [4:0] plug_slot = 0, unplug_slot = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [4:0] reg_addr = 0;
  logic [3:0] reg_be = 4'hF;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic reg_rvalid, evt_pulse, eject_valid;
  logic [1:0] eject_bus;
  logic [4:0] eject_slot;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hp_status_bank #(.NBUS(NBUS), .EVB(EVB), .IDXW(IDXW)) u0 (.*);

  initial begin
    slot_fixed_mask = '0;
    slot_fixed_mask[3]  = 1'b1;  // bus 0 slot 3
    slot_fixed_mask[32] = 1'b1;  // bus 1 slot 0
    for (int i = 0; i < NBUS * 32; i++) slot_name_idx[i*IDXW +: IDXW] = 16'h100 + 16'(i);
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0;
    check(reg_rvalid && reg_rdata == exp, req, reg_rdata, exp);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic ev(input bit dn, input logic [7:0] b, input logic [4:0] s);
    @(negedge clk);
    if (dn) begin unplug_valid = 1; unplug_bus = b; unplug_slot = s; end
    else    begin plug_valid = 1;   plug_bus = b;   plug_slot = s;   end
    @(negedge clk); plug_valid = 0; unplug_valid = 0;
  endtask

  // {op[1:0], addr[4:0], data[31:0], exp[31:0]}; op 0 write, 1 read, 2 plug, 3 unplug.
  // Plug/unplug data: [15:8] bus, [4:0] slot; exp[0] = expected evt_pulse.
  // Write exp: [16] pulse expected, [9:8] bus, [4:0] slot.
  localparam logic [70:0] VECS [0:22] = '{
    {2'd1, 5'h10, 32'h0,      32'h0},        // R7 select starts at 0
    {2'd2, 5'h00, 32'h0005,   32'h1},        // R2 plug bus0 slot5
    {2'd3, 5'h00, 32'h0009,   32'h1},        // R2 unplug bus0 slot9
    {2'd1, 5'h00, 32'h0,      32'h20},       // R3 arrived bitmap
    {2'd1, 5'h00, 32'h0,      32'h0},        // R6 cleared by read
    {2'd1, 5'h04, 32'h0,      32'h200},      // R3 leaving bitmap
    {2'd1, 5'h0C, 32'h0,      32'hFFFFFFF7}, // R3 removable mask
    {2'd0, 5'h08, 32'h200,    32'h10009},    // R4 eject bus0 slot9
    {2'd1, 5'h04, 32'h0,      32'h0},        // R4 cleared
    {2'd2, 5'h00, 32'h0100,   32'h1},        // R2 plug bus1 slot0
    {2'd0, 5'h10, 32'h1,      32'h0},        // R7 select bus1
    {2'd1, 5'h10, 32'h0,      32'h1},        // R7
    {2'd1, 5'h00, 32'h0,      32'h1},        // R3
    {2'd1, 5'h0C, 32'h0,      32'hFFFFFFFE}, // R3
    {2'd3, 5'h00, 32'h0100,   32'h1},        // R2 unplug bus1 slot0
    {2'd0, 5'h08, 32'h1,      32'h0},        // R4 fixed slot: no pulse
    {2'd1, 5'h04, 32'h0,      32'h0},        // R4 still cleared
    {2'd0, 5'h14, 32'h10,     32'h0},        // R8 prime slot4
    {2'd1, 5'h14, 32'h0,      32'h124},      // R8 index of bus1 slot4
    {2'd1, 5'h14, 32'h0,      32'h0},        // R8 cleared by read
    {2'd2, 5'h00, 32'h0201,   32'h0},        // R2 bus2 not capable
    {2'd0, 5'h10, 32'h7,      32'h0},        // R7 out-of-range select
    {2'd1, 5'h10, 32'h0,      32'h0}         // R7 reads zero
  };

  function automatic string vtag(input logic [1:0] op, input logic [4:0] a, input logic [31:0] e);
    if (op >= 2) return "R2";
    if (op == 0) return (a == 5'h08) ? "R4" : (a == 5'h14) ? "R8" : "R7";
    if (a == 5'h14) return "R8";
    if (a == 5'h10) return "R7";
    if (a == 5'h00 && e == 0) return "R6";
    return "R3";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(!evt_pulse && !eject_valid && !reg_rvalid, "R1", {29'h0, evt_pulse, eject_valid, reg_rvalid}, 32'h0);
    rd(5'h00, 32'h0, "R1");
    rd(5'h14, 32'h0, "R1");

    for (int i = 0; i < 23; i++) begin
      logic [1:0] op; logic [4:0] a; logic [31:0] d, e;
      {op, a, d, e} = VECS[i];
      case (op)
        2'd0: begin
          wr(a, d);
          check(eject_valid == e[16] && (!e[16] || (eject_bus == e[9:8] && eject_slot == e[4:0])),
                vtag(op, a, e), {15'h0, eject_valid, 6'h0, eject_bus, 3'h0, eject_slot}, e);
        end
        2'd1: rd(a, e, vtag(op, a, e));
        default: begin
          ev(op == 2'd3, d[15:8], d[4:0]);
          check(evt_pulse == e[0], vtag(op, a, e), {31'h0, evt_pulse}, e);
        end
      endcase
    end

    // R10 malformed accesses
    wr(5'h10, 32'h3);
    @(negedge clk); reg_wr = 1; reg_addr = 5'h10; reg_be = 4'h3; reg_wdata = 0;
    @(negedge clk); reg_addr = 5'h11; reg_be = 4'hF;
    @(negedge clk); reg_wr = 0; reg_rd = 1; reg_addr = 5'h10; reg_be = 4'h3;
    @(negedge clk); reg_rd = 0; reg_be = 4'hF;
    check(!reg_rvalid, "R10", {31'h0, reg_rvalid}, 32'h0);
    rd(5'h10, 32'h3, "R10");

    // R9 simultaneous plug and unplug on bus3
    @(negedge clk); plug_valid = 1; plug_bus = 3; plug_slot = 1;
                    unplug_valid = 1; unplug_bus = 3; unplug_slot = 2;
    @(negedge clk); plug_valid = 0; unplug_valid = 0;
    check(evt_pulse, "R9", {31'h0, evt_pulse}, 32'h1);
    rd(5'h04, 32'h4, "R9");
    // R9 clearing read and new plug in same cycle: set wins
    @(negedge clk); reg_rd = 1; reg_addr = 5'h00; plug_valid = 1; plug_bus = 3; plug_slot = 6;
    @(negedge clk); reg_rd = 0; plug_valid = 0;
    check(reg_rdata == 32'h2, "R9", reg_rdata, 32'h2);
    rd(5'h00, 32'h40, "R9");
    // R9 eject and unplug of same slot in same cycle: bit stays, eject still issued
    @(negedge clk); reg_wr = 1; reg_addr = 5'h08; reg_wdata = 32'h4;
                    unplug_valid = 1; unplug_bus = 3; unplug_slot = 2;
    @(negedge clk); reg_wr = 0; unplug_valid = 0;
    check(eject_valid && eject_bus == 2'd3 && eject_slot == 5'd2, "R9",
          {eject_valid, 22'h0, eject_bus, 2'h0, eject_slot}, {1'b1, 22'h0, 2'd3, 2'h0, 5'd2});
    rd(5'h04, 32'h4, "R9");

    // R5 zero data ignored
    wr(5'h08, 32'h0);
    check(!eject_valid, "R5", {31'h0, eject_valid}, 32'h0);
    rd(5'h04, 32'h4, "R5");
    // R4 lowest set bit selects the slot
    wr(5'h08, 32'hC);
    check(eject_valid && eject_slot == 5'd2 && eject_bus == 2'd3, "R4",
          {25'h0, eject_bus, eject_slot}, {25'h0, 2'd3, 5'd2});
    rd(5'h04, 32'h0, "R4");
    // R5 bus without hotplug capability
    wr(5'h10, 32'h2);
    wr(5'h08, 32'h1);
    check(!eject_valid, "R5", {31'h0, eject_valid}, 32'h0);

    // R8 holder cleared by an unrelated write
    wr(5'h10, 32'h0);
    wr(5'h14, 32'h8);
    rd(5'h14, 32'h103, "R8");
    wr(5'h14, 32'h8);
    wr(5'h10, 32'h0);
    rd(5'h14, 32'h0, "R8");

    // R6/R7 with bridge mode off
    cfg_bridge_mode = 0;
    wr(5'h10, 32'h3);
    rd(5'h10, 32'h0, "R7");
    ev(0, 8'd0, 5'd7);
    rd(5'h00, 32'h80, "R6");
    rd(5'h00, 32'h80, "R6");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule